// File: doc/BRIEF.md
# UART Transmit and Receive Byte Queues

This block holds the character buffering of a 16550-style serial port. Host writes to the transmit holding location go into a transmit queue. The transmit shift logic drains that queue from its head. Bytes that the receive shift logic assembles go into a receive queue, each stored with its three per-character error bits. The host drains the receive queue by reading.

The block drives two active-low ready outputs from the fill state of the queues. It also raises a receive interrupt request once the receive fill reaches one of four selectable thresholds. A mode input reduces each direction to a single-byte holding register. Each queue has its own clear input, so software can flush one direction without disturbing the other.

Top module: `uart_fifo_pair`

## Requirements
- R1: With `fifoEn`=1 the transmit queue holds up to 16 bytes. They leave at `txData` in the order written. `txValid` is 1 whenever at least one byte is queued.
- R2: Each receive entry stores the byte on `rxPushData` and the error bits on `rxPushErr` (bit 0 parity, bit 1 framing, bit 2 break). Both come back unaltered, in arrival order, on `rxData` and `rxErr`.
- R3: `rxRdy_n` is 0 exactly while at least one unread received byte is held. It is 1 when none is held.
- R4: `txRdy_n` is 0 while at least one transmit slot is free. It is 1 when none is free.
- R5: A host write while the transmit side is full is dropped. The queued bytes and their order do not change.
- R6: A receive push while the receive side is full sets `rxOverrun` and leaves the stored entries unchanged. `rxOverrun` stays set until `rxFlush`.
- R7: With `fifoEn`=1, `rxIrq` is 1 while the receive fill is at least the level chosen by `rxTrigSel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R8: With `fifoEn`=0 each direction holds exactly one byte. `rxIrq` then equals "one byte held", whatever the value of `rxTrigSel`.
- R9: `txFlush` empties only the transmit side. `rxFlush` empties only the receive side and clears `rxOverrun`.
- R10: A write and a transmit pop in the same cycle on a non-empty, non-full queue keep the fill level and the byte order.
- R11: After reset `rxRdy_n`=1, `txRdy_n`=0, `txValid`=0, `rxIrq`=0 and `rxOverrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | 1: 16-entry queues, 0: single holding registers |
| rxTrigSel | input | 2 | Receive interrupt threshold select |
| txFlush | input | 1 | Empty the transmit side |
| rxFlush | input | 1 | Empty the receive side and clear overrun |
| hostWrEn | input | 1 | Host write strobe to transmit holding |
| hostWrData | input | 8 | Host write byte |
| txPop | input | 1 | Shift logic takes the head transmit byte |
| txData | output | 8 | Head transmit byte |
| txValid | output | 1 | Transmit side non-empty |
| rxPush | input | 1 | Shift logic delivers a received byte |
| rxPushData | input | 8 | Received byte |
| rxPushErr | input | 3 | Error bits of the received byte |
| hostRdEn | input | 1 | Host read strobe, removes head receive entry |
| rxData | output | 8 | Head received byte |
| rxErr | output | 3 | Error bits of the head received byte |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| rxRdy_n | output | 1 | Active-low receive data available |
| txRdy_n | output | 1 | Active-low transmit space available |
| rxIrq | output | 1 | Receive threshold interrupt request |

## Verification
A wrong fill count shows at the ready pins on the first edge after the bad update. A count one too high drives `txRdy_n` high one write early. A count off by one on the receive side moves the `rxIrq` edge off the selected threshold. A corrupted read or write pointer shows as a wrong byte or error triple on `rxData`, `rxErr` or `txData`. That appears at the next drained entry, so the bench checks every entry as it is popped.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifo_strobe_t;
endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  uart_fifo_pkg::fifo_strobe_t stb,
  input  logic [WIDTH-1:0]            wrData,
  output logic [WIDTH-1:0]            rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.clear) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/uart_fifo_dp.sv
module uart_fifo_dp #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  uart_fifo_pkg::fifo_strobe_t txStb,
  input  uart_fifo_pkg::fifo_strobe_t rxStb,
  input  logic [DATA_W-1:0]           hostWrData,
  input  logic [DATA_W-1:0]           rxPushData,
  input  logic [ERR_W-1:0]            rxPushErr,
  output logic [DATA_W-1:0]           txData,
  output logic [DATA_W-1:0]           rxData,
  output logic [ERR_W-1:0]            rxErr
);
  localparam int RX_W = DATA_W + ERR_W;

  logic [RX_W-1:0] rxHead;

  uart_fifo_store #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txStore (
    .clk(clk), .rst_n(rst_n), .stb(txStb),
    .wrData(hostWrData), .rdData(txData)
  );

  uart_fifo_store #(.WIDTH(RX_W), .DEPTH(DEPTH)) rxStore (
    .clk(clk), .rst_n(rst_n), .stb(rxStb),
    .wrData({rxPushErr, rxPushData}), .rdData(rxHead)
  );

  assign rxData = rxHead[DATA_W-1:0];
  assign rxErr  = rxHead[RX_W-1:DATA_W];
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fifoEn,
  input  logic [1:0]                  rxTrigSel,
  input  logic                        txFlush,
  input  logic                        rxFlush,
  input  logic                        hostWrEn,
  input  logic                        txPop,
  input  logic                        rxPush,
  input  logic                        hostRdEn,
  output uart_fifo_pkg::fifo_strobe_t txStb,
  output uart_fifo_pkg::fifo_strobe_t rxStb,
  output logic                        txValid,
  output logic                        txRdy_n,
  output logic                        rxRdy_n,
  output logic                        rxIrq,
  output logic                        rxOverrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] txCnt, rxCnt, cap, trigLvl;
  logic             txFull, rxFull, rxOvrQ;

  assign cap    = fifoEn ? FULL_LVL : CNT_W'(1);
  assign txFull = (txCnt >= cap);
  assign rxFull = (rxCnt >= cap);

  always_comb begin
    txStb.clear = txFlush;
    txStb.push  = hostWrEn && !txFull && !txFlush;
    txStb.pop   = txPop && (txCnt != '0) && !txFlush;
    rxStb.clear = rxFlush;
    rxStb.push  = rxPush && !rxFull && !rxFlush;
    rxStb.pop   = hostRdEn && (rxCnt != '0) && !rxFlush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       txCnt <= '0;
    else if (txStb.clear)             txCnt <= '0;
    else if (txStb.push && !txStb.pop) txCnt <= txCnt + 1'b1;
    else if (!txStb.push && txStb.pop) txCnt <= txCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rxCnt <= '0;
    else if (rxStb.clear)             rxCnt <= '0;
    else if (rxStb.push && !rxStb.pop) rxCnt <= rxCnt + 1'b1;
    else if (!rxStb.push && rxStb.pop) rxCnt <= rxCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rxOvrQ <= 1'b0;
    else if (rxFlush)          rxOvrQ <= 1'b0;
    else if (rxPush && rxFull) rxOvrQ <= 1'b1;
  end

  always_comb begin
    case (rxTrigSel)
      2'd0:    trigLvl = CNT_W'(TRIG_0);
      2'd1:    trigLvl = CNT_W'(TRIG_1);
      2'd2:    trigLvl = CNT_W'(TRIG_2);
      default: trigLvl = CNT_W'(TRIG_3);
    endcase
  end

  assign txValid   = (txCnt != '0);
  assign txRdy_n   = txFull;
  assign rxRdy_n   = (rxCnt == '0);
  assign rxIrq     = fifoEn ? (rxCnt >= trigLvl) : (rxCnt != '0);
  assign rxOverrun = rxOvrQ;
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifoEn,
  input  logic [1:0]        rxTrigSel,
  input  logic              txFlush,
  input  logic              rxFlush,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic [ERR_W-1:0]  rxPushErr,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic [ERR_W-1:0]  rxErr,
  output logic              rxOverrun,
  output logic              rxRdy_n,
  output logic              txRdy_n,
  output logic              rxIrq
);
  uart_fifo_pkg::fifo_strobe_t txStb, rxStb;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .rxTrigSel(rxTrigSel),
    .txFlush(txFlush), .rxFlush(rxFlush), .hostWrEn(hostWrEn),
    .txPop(txPop), .rxPush(rxPush), .hostRdEn(hostRdEn),
    .txStb(txStb), .rxStb(rxStb), .txValid(txValid), .txRdy_n(txRdy_n),
    .rxRdy_n(rxRdy_n), .rxIrq(rxIrq), .rxOverrun(rxOverrun)
  );

  uart_fifo_dp #(.DATA_W(DATA_W), .ERR_W(ERR_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .txStb(txStb), .rxStb(rxStb),
    .hostWrData(hostWrData), .rxPushData(rxPushData), .rxPushErr(rxPushErr),
    .txData(txData), .rxData(rxData), .rxErr(rxErr)
  );
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifoEn,
  input logic              txFlush,
  input logic              rxFlush,
  input logic              hostWrEn,
  input logic              txPop,
  input logic [DATA_W-1:0] txData,
  input logic              txValid,
  input logic              rxPush,
  input logic              hostRdEn,
  input logic              rxOverrun,
  input logic              rxRdy_n,
  input logic              txRdy_n,
  input logic              rxIrq
);
  AST_RX_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rxPush && !rxFlush && !hostRdEn |=> !rxRdy_n); // R3

  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    txRdy_n && hostWrEn && !txPop && !txFlush |=> txRdy_n || (fifoEn != $past(fifoEn))); // R5

  AST_TX_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    txValid && !txPop && !txFlush |=> txValid && $stable(txData)); // R1

  AST_SINGLE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn && !rxRdy_n && rxPush && !rxFlush |=> rxOverrun); // R6

  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txFlush |=> !txValid && !txRdy_n); // R9

  AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rxFlush |=> rxRdy_n && !rxIrq && !rxOverrun); // R9

  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> !rxRdy_n); // R7
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .txFlush(txFlush),
  .rxFlush(rxFlush), .hostWrEn(hostWrEn), .txPop(txPop), .txData(txData),
  .txValid(txValid), .rxPush(rxPush), .hostRdEn(hostRdEn),
  .rxOverrun(rxOverrun), .rxRdy_n(rxRdy_n), .txRdy_n(txRdy_n), .rxIrq(rxIrq)
);

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifoEn = 1'b1;
  logic [1:0] rxTrigSel = 2'd0;
  logic txFlush = 1'b0, rxFlush = 1'b0;
  logic hostWrEn = 1'b0, txPop = 1'b0, rxPush = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0, rxPushData = '0;
  logic [2:0] rxPushErr = '0;
  logic [7:0] txData, rxData;
  logic [2:0] rxErr;
  logic txValid, rxOverrun, rxRdy_n, txRdy_n, rxIrq;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .rxTrigSel(rxTrigSel),
    .txFlush(txFlush), .rxFlush(rxFlush), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .txPop(txPop), .txData(txData), .txValid(txValid),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPushErr(rxPushErr),
    .hostRdEn(hostRdEn), .rxData(rxData), .rxErr(rxErr), .rxOverrun(rxOverrun),
    .rxRdy_n(rxRdy_n), .txRdy_n(txRdy_n), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wrTx(input logic [7:0] d);
    hostWrEn = 1'b1; hostWrData = d; tick(); hostWrEn = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1; tick(); txPop = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d, input logic [2:0] e);
    rxPush = 1'b1; rxPushData = d; rxPushErr = e; tick(); rxPush = 1'b0;
  endtask

  task automatic rdRx();
    hostRdEn = 1'b1; tick(); hostRdEn = 1'b0;
  endtask

  task automatic flushBoth();
    txFlush = 1'b1; rxFlush = 1'b1; tick(); txFlush = 1'b0; rxFlush = 1'b0;
  endtask

  function automatic int trigOf(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R11 rxRdy_n", rxRdy_n, 1);
    chk("R11 txRdy_n", txRdy_n, 0);
    chk("R11 txValid", txValid, 0);
    chk("R11 rxIrq", rxIrq, 0);
    chk("R11 rxOverrun", rxOverrun, 0);

    // R4 fill sweep; R5 drop on full; R1 order
    for (int i = 0; i < 16; i++) begin
      wrTx(8'(8'h30 + i));
      chk("R4 txRdy_n during fill", txRdy_n, (i == 15) ? 1 : 0);
      chk("R1 txValid", txValid, 1);
    end
    wrTx(8'hEE);
    chk("R5 txRdy_n stays full", txRdy_n, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R1 R5 tx order", txData, 8'h30 + i);
      popTx();
      chk("R4 txRdy_n after pop", txRdy_n, 0);
    end
    chk("R1 txValid empty", txValid, 0);

    // R7 thresholds, R2 entries, R6 overrun, R3 ready
    for (int sel = 0; sel < 4; sel++) begin
      rxTrigSel = 2'(sel);
      flushBoth();
      for (int n = 1; n <= 16; n++) begin
        pushRx(8'(sel * 16 + n), 3'(n));
        chk("R7 rxIrq level", rxIrq, (n >= trigOf(sel)) ? 1 : 0);
        chk("R3 rxRdy_n held", rxRdy_n, 0);
      end
      chk("R6 no overrun yet", rxOverrun, 0);
      pushRx(8'hFF, 3'd7);
      chk("R6 overrun set", rxOverrun, 1);
      for (int n = 1; n <= 16; n++) begin
        chk("R2 rxData", rxData, (sel * 16 + n) & 8'hFF);
        chk("R2 rxErr", rxErr, n % 8);
        rdRx();
      end
      chk("R3 rxRdy_n empty", rxRdy_n, 1);
      chk("R6 overrun sticky", rxOverrun, 1);
    end

    // R9 independent flushes
    flushBoth();
    wrTx(8'hA1); wrTx(8'hA2);
    pushRx(8'h5A, 3'd5);
    txFlush = 1'b1; tick(); txFlush = 1'b0;
    chk("R9 tx emptied", txValid, 0);
    chk("R9 rx kept", rxRdy_n, 0);
    chk("R9 rx data kept", rxData, 8'h5A);
    wrTx(8'hB7);
    rxFlush = 1'b1; tick(); rxFlush = 1'b0;
    chk("R9 rx emptied", rxRdy_n, 1);
    chk("R9 overrun cleared", rxOverrun, 0);
    chk("R9 tx kept", txData, 8'hB7);
    chk("R9 tx valid kept", txValid, 1);

    // R8 single holding register mode
    fifoEn = 1'b0; rxTrigSel = 2'd3;
    flushBoth();
    chk("R8 tx free", txRdy_n, 0);
    wrTx(8'h11);
    chk("R8 tx full after one", txRdy_n, 1);
    wrTx(8'h22);
    chk("R8 R5 second write dropped", txData, 8'h11);
    popTx();
    chk("R8 tx empty", txValid, 0);
    pushRx(8'h33, 3'd1);
    chk("R8 rxIrq one byte", rxIrq, 1);
    chk("R8 rxRdy_n", rxRdy_n, 0);
    pushRx(8'h44, 3'd2);
    chk("R8 R6 overrun", rxOverrun, 1);
    chk("R8 R6 data kept", rxData, 8'h33);
    chk("R8 R6 err kept", rxErr, 1);
    rdRx();
    chk("R8 rx empty", rxRdy_n, 1);
    chk("R8 rxIrq clear", rxIrq, 0);

    // R10 simultaneous write and pop
    fifoEn = 1'b1;
    flushBoth();
    wrTx(8'hC0); wrTx(8'hC1);
    hostWrEn = 1'b1; hostWrData = 8'hC2; txPop = 1'b1; tick();
    hostWrEn = 1'b0; txPop = 1'b0;
    chk("R10 head after swap", txData, 8'hC1);
    popTx();
    chk("R10 next", txData, 8'hC2);
    popTx();
    chk("R10 empty after two", txValid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule